// File: doc/BRIEF.md
# Johnson Counter Seven-Segment Display

This block runs a four-stage twisted-ring counter that takes one step roughly each second. Each of its four bits is shown as the character 0 or 1 on a seven-segment display of its own, so the four displays together read as the counter pattern, for example 1110. A prescaler divides the fast system clock and produces an enable that is one clock wide. The register moves only on cycles where that enable is high.

The divide ratio `DIV` is a parameter. Its default gives one step per second at 125 MHz, and a small value keeps a simulation short. The parameter `ACTIVE_LOW` inverts every segment output for displays that light a segment on a low level. The external reset `rst_n` is active low. It clears the design at once, and its release is synchronized to the clock through two stages. The raw counter state is also driven out for observation.

Top module: `jc_seg_display`

## Requirements
- R1: While `rst_n` is low, `state_o` is 0000 and every display shows the 0 glyph. This takes effect at once, with no clock edge needed.
- R2: After `rst_n` rises, the first change of `state_o` follows the (DIV+2)-th rising clock edge. Two of these edges are used by the reset synchronizer, and DIV edges are one prescaler period.
- R3: After the first step, `state_o` changes exactly once every DIV clocks and holds its value on every other cycle.
- R4: Each step moves the state one place toward bit 0, and bit 3 takes the inverse of the old bit 0. From reset the states run 0000, 1000, 1100, 1110, 1111, 0111, 0011, 0001 and then back to 0000.
- R5: Display d (`seg0_o` to `seg3_o`) shows state bit d. Vector bit 6 is segment g and bit 0 is segment a, with 1 meaning lit. A one shows as 0000110 and a zero shows as 0111111.
- R6: With `ACTIVE_LOW`=1, every segment bit is the inverse of its R5 value. A one then shows as 1111001 and a zero as 1000000.
- R7: A reset in the middle of a run also clears the prescaler. After the next release, the first step again comes DIV+2 edges later.
- R8: `state_o` only ever holds one of the eight states listed in R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low, release synchronized inside |
| seg0_o | output | 7 | Segments g..a of the display for state bit 0 |
| seg1_o | output | 7 | Segments g..a of the display for state bit 1 |
| seg2_o | output | 7 | Segments g..a of the display for state bit 2 |
| seg3_o | output | 7 | Segments g..a of the display for state bit 3 |
| state_o | output | 4 | Raw counter state |

## Verification
The bench builds two copies of the block. The first uses DIV=5 with active-high segments. The second uses DIV=3 with `ACTIVE_LOW`=1, so a full eight-state cycle takes only 40 or 24 clocks. Several full wraps of the sequence then fit into each run, together with the exact first-step latency after reset release and the inverted glyphs. A reset asserted in the middle of a cycle, followed by a second release, shows that the prescaler phase restarts along with the register.

// File: rtl/jc_pkg.sv
package jc_pkg;
  localparam int unsigned JC_BITS = 4;
  localparam int unsigned SEG_W   = 7;

  typedef logic [SEG_W-1:0] seg_t;

  // segment order g,f,e,d,c,b,a; 1 = lit
  localparam seg_t GLYPH_ZERO = 7'b0111111;
  localparam seg_t GLYPH_ONE  = 7'b0000110;
endpackage

// File: rtl/jc_rst_sync.sv
module jc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/jc_tick_gen.sv
module jc_tick_gen #(
  parameter int unsigned DIV = 125_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          at_last;

  always_comb begin
    at_last = (cnt_q == LAST);
    cnt_d   = at_last ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = at_last;
endmodule

// File: rtl/jc_twist_reg.sv
module jc_twist_reg #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] q
);
  logic [W-1:0] ring_q;
  logic [W-1:0] ring_d;

  always_comb begin
    ring_d = ring_q;
    if (step) ring_d = {~ring_q[0], ring_q[W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ring_q <= '0;
    else if (step) ring_q <= ring_d;
  end

  assign q = ring_q;
endmodule

// File: rtl/jc_glyph_enc.sv
module jc_glyph_enc
  import jc_pkg::*;
#(
  parameter bit ACTIVE_LOW = 1'b0
) (
  input  logic bit_i,
  output seg_t seg_o
);
  seg_t glyph;

  always_comb begin
    glyph = bit_i ? GLYPH_ONE : GLYPH_ZERO;
  end

  generate
    if (ACTIVE_LOW) begin : g_low
      assign seg_o = ~glyph;
    end else begin : g_high
      assign seg_o = glyph;
    end
  endgenerate
endmodule

// File: rtl/jc_seg_display.sv
module jc_seg_display
  import jc_pkg::*;
#(
  parameter int unsigned DIV        = 125_000_000,
  parameter bit          ACTIVE_LOW = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic [6:0] seg0_o,
  output logic [6:0] seg1_o,
  output logic [6:0] seg2_o,
  output logic [6:0] seg3_o,
  output logic [3:0] state_o
);
  logic               rst_sync_n;
  logic               tick_w;
  logic [JC_BITS-1:0] ring_w;
  seg_t               glyphs [JC_BITS];

  jc_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  jc_tick_gen #(.DIV(DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .tick  (tick_w)
  );

  jc_twist_reg #(.W(JC_BITS)) u_ring (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .step  (tick_w),
    .q     (ring_w)
  );

  generate
    for (genvar d = 0; d < JC_BITS; d++) begin : g_digit
      jc_glyph_enc #(.ACTIVE_LOW(ACTIVE_LOW)) u_enc (
        .bit_i (ring_w[d]),
        .seg_o (glyphs[d])
      );
    end
  endgenerate

  assign seg0_o  = glyphs[0];
  assign seg1_o  = glyphs[1];
  assign seg2_o  = glyphs[2];
  assign seg3_o  = glyphs[3];
  assign state_o = ring_w;
endmodule

// File: rtl/jc_seg_display_chk.sv
module jc_seg_display_chk
  import jc_pkg::*;
#(
  parameter int unsigned DIV        = 125_000_000,
  parameter bit          ACTIVE_LOW = 1'b0
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic [3:0] state,
  input logic [6:0] seg0,
  input logic [6:0] seg1,
  input logic [6:0] seg2,
  input logic [6:0] seg3
);
  localparam seg_t MASK = ACTIVE_LOW ? 7'h7F : 7'h00;

  function automatic logic legal(input logic [3:0] s);
    case (s)
      4'b0000, 4'b1000, 4'b1100, 4'b1110,
      4'b1111, 4'b0111, 4'b0011, 4'b0001: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic seg_t want(input logic b);
    return (b ? GLYPH_ONE : GLYPH_ZERO) ^ MASK;
  endfunction

  int unsigned gap;
  logic        seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap  <= 0;
      seen <= 1'b0;
    end else if (tick) begin
      gap  <= 0;
      seen <= 1'b1;
    end else begin
      gap  <= gap + 1;
    end
  end

  a_r1_reset_clear: assert property (@(posedge clk) !rst_n |-> (state == 4'b0000));

  a_r2_first_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !seen) |-> (gap == DIV + 1));

  a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && seen) |-> (gap == DIV - 1));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(state));

  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (state == {~$past(state[0]), $past(state[3:1])}));

  a_r5_digits: assert property (@(posedge clk) disable iff (!rst_n)
    (seg0 == want(state[0])) && (seg1 == want(state[1])) &&
    (seg2 == want(state[2])) && (seg3 == want(state[3])));

  a_r6_polarity: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(seg3 ^ MASK) == 6) || ($countones(seg3 ^ MASK) == 2));

  a_r8_legal: assert property (@(posedge clk) disable iff (!rst_n) legal(state));
endmodule

bind jc_seg_display jc_seg_display_chk #(.DIV(DIV), .ACTIVE_LOW(ACTIVE_LOW)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .tick  (tick_w),
  .state (state_o),
  .seg0  (seg0_o),
  .seg1  (seg1_o),
  .seg2  (seg2_o),
  .seg3  (seg3_o)
);

// File: tb/jc_seg_display_bench.sv
module jc_seg_display_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic run_chk = 1'b0;
  always #4 clk = ~clk;

  int total = 0;
  int fails = 0;
  int k = 0;

  localparam int DIV_A = 5;
  localparam int DIV_B = 3;
  int   divs [2] = '{DIV_A, DIV_B};
  bit   inv  [2] = '{1'b0, 1'b1};
  logic [3:0] seq [8] = '{4'b0000, 4'b1000, 4'b1100, 4'b1110,
                          4'b1111, 4'b0111, 4'b0011, 4'b0001};

  logic [3:0] st [2];
  logic [6:0] sg [2][4];

  logic [3:0] prev   [2];
  bit         first  [2];
  int         last_k [2];
  bit         restarted = 1'b0;

  jc_seg_display #(.DIV(DIV_A), .ACTIVE_LOW(1'b0)) u_jc_seg_display (
    .clk(clk), .rst_n(rst_n),
    .seg0_o(sg[0][0]), .seg1_o(sg[0][1]), .seg2_o(sg[0][2]), .seg3_o(sg[0][3]),
    .state_o(st[0])
  );

  jc_seg_display #(.DIV(DIV_B), .ACTIVE_LOW(1'b1)) u_jc_seg_display_inv (
    .clk(clk), .rst_n(rst_n),
    .seg0_o(sg[1][0]), .seg1_o(sg[1][1]), .seg2_o(sg[1][2]), .seg3_o(sg[1][3]),
    .state_o(st[1])
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] glyph(input logic b, input bit low);
    logic [6:0] g;
    g = b ? 7'b0000110 : 7'b0111111;
    return low ? ~g : g;
  endfunction

  function automatic bit is_legal(input logic [3:0] s);
    for (int j = 0; j < 8; j++) if (seq[j] == s) return 1'b1;
    return 1'b0;
  endfunction

  // edges since the last reset release
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) k <= 0;
    else        k <= k + 1;
  end

  task automatic clear_trackers();
    for (int i = 0; i < 2; i++) begin
      prev[i] = 4'b0000; first[i] = 1'b1; last_k[i] = 0;
    end
  endtask

  task automatic check_reset_state(input string tag);
    for (int i = 0; i < 2; i++) begin
      chk(st[i] == 4'b0000, tag, 32'(st[i]), 32'h0);
      for (int d = 0; d < 4; d++)
        chk(sg[i][d] == glyph(1'b0, inv[i]), tag, 32'(sg[i][d]), 32'(glyph(1'b0, inv[i])));
    end
  endtask

  task automatic check_unit(input int i);
    int steps;
    logic [3:0] exp;
    steps = (k >= 2) ? (k - 2) / divs[i] : 0;
    exp = seq[steps % 8];
    chk(st[i] == exp, "R4 sequence / R3 hold", 32'(st[i]), 32'(exp));
    chk(is_legal(st[i]), "R8 legal state", 32'(st[i]), 32'(exp));
    for (int d = 0; d < 4; d++)
      chk(sg[i][d] == glyph(exp[d], inv[i]), inv[i] ? "R6 inverted glyph" : "R5 glyph",
          32'(sg[i][d]), 32'(glyph(exp[d], inv[i])));
    if (st[i] != prev[i]) begin
      if (first[i])
        chk(k == divs[i] + 2, restarted ? "R7 restart latency" : "R2 first step latency",
            32'(k), 32'(divs[i] + 2));
      else
        chk(k - last_k[i] == divs[i], "R3 step period", 32'(k - last_k[i]), 32'(divs[i]));
      first[i]  = 1'b0;
      last_k[i] = k;
    end
    prev[i] = st[i];
  endtask

  always @(negedge clk) begin
    if (rst_n && run_chk) begin
      check_unit(0);
      check_unit(1);
    end
  end

  initial begin
    rst_n = 1'b1;
    clear_trackers();
    #1 rst_n = 1'b0;
    #1 check_reset_state("R1 reset before clock");
    repeat (3) @(posedge clk);
    #2 check_reset_state("R1 reset held");
    rst_n = 1'b1;
    run_chk = 1'b1;
    repeat (100) @(posedge clk);
    #2 rst_n = 1'b0;
    run_chk = 1'b0;
    #1 check_reset_state("R1 async reset mid-run");
    clear_trackers();
    restarted = 1'b1;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    run_chk = 1'b1;
    repeat (100) @(posedge clk);
    #1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(8 * 20000);
    chk(1'b0, "watchdog expired, all R", 32'h0, 32'h1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule